// File: doc/BRIEF.md
# Synthetic Packet Traffic Source for Network Endpoints

This block sits at one endpoint of an on-chip packet network and generates test traffic for it. Each cycle in which it is idle and enabled, it draws a pseudo-random number and compares it against a programmable load level. When a packet is launched, the block picks a destination node and a virtual channel, then sends a fixed-length multi-flit packet. Each flit carries sideband wires for valid, head, tail, destination and channel, so no separate header flit is needed. Sweeping the load level while measuring latency gives a load-latency curve for the network under test.

There are two destination patterns. In the uniform pattern every node other than this one is a candidate. If the draw lands on this node's own address, that injection slot is skipped. In the locality-biased pattern a programmable fraction of packets goes to one of the two ring neighbours, and the rest follow the uniform rule. A setting of 230/256 gives roughly 90% neighbour traffic. The packet length is half the flit buffer depth, so four flits with an eight-entry buffer. The network supplies one space-available bit per channel, and the source holds its packet whenever the channel it chose has no room.

Each head flit carries the cycle on which the packet was launched. A sink-side accumulator in the same block takes an arriving head's timestamp and adds the elapsed time since then to a running latency total. It also counts the received packets.

Top module: `noc_traffic_gen`

## Requirements
- R1: After reset, `flit_valid` is 0, `lat_sum` is 0 and `pkt_cnt` is 0.
- R2: A packet is exactly BUF_DEPTH/2 flits (4 by default), sent in order. `flit_head` is 1 on the first flit only and `flit_tail` on the last flit only. Bits [17:16] of `flit_data` give the flit index 0..3. `flit_dest` and `flit_vc` stay constant across the packet.
- R3: A flit is presented only in a cycle where `vc_ready[flit_vc]` is 1. A stalled packet resumes at the flit where it stopped once space returns.
- R4: `load_rate` (9 bits) sets how often a packet is launched, as a fraction out of 256. At 0 no packet starts. At 256, with all channels ready, every packet starts exactly one idle cycle after the previous tail.
- R5: With `mode`=0 (uniform), the destination is never `self_addr`, and nodes other than the two neighbours do receive packets.
- R6: With `mode`=1 (locality-biased) and `local_frac`=256, every destination is `self_addr`+1 or `self_addr`-1, taken modulo NODES.
- R7: The virtual channel of each packet is drawn at random, so over a run every channel carries packets.
- R8: Bits [15:0] of `flit_data` hold the value of the free-running cycle counter from the launch cycle. This is the cycle just before the head when the channel is not stalled. The counter starts at 0 after reset. Bits [21:18] hold `self_addr`.
- R9: While `en` is 0, the random state reloads from `seed` (a zero seed is replaced by 1), and no new packet starts, although a packet already in flight completes. Two runs from the same seed and settings produce the same sequence of destinations and channels.
- R10: When `rx_valid` and `rx_head` are both 1, the next cycle shows `lat_sum` grown by (counter − `rx_ts`) mod 2^16 and `pkt_cnt` grown by 1. Any other `rx_*` combination leaves both unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Run enable; low reloads the seed |
| mode | input | 1 | 0 uniform, 1 locality-biased |
| seed | input | LFSR_W | Random seed |
| self_addr | input | log2(NODES) | This endpoint's node number |
| load_rate | input | LOAD_W+1 | Launch probability out of 2^LOAD_W |
| local_frac | input | LOAD_W+1 | Neighbour fraction out of 2^LOAD_W |
| vc_ready | input | NUM_VC | Per-channel space available |
| flit_valid | output | 1 | Flit presented and taken |
| flit_head | output | 1 | First flit of packet |
| flit_tail | output | 1 | Last flit of packet |
| flit_dest | output | log2(NODES) | Destination node |
| flit_vc | output | log2(NUM_VC) | Virtual channel |
| flit_data | output | FLIT_W | Timestamp, flit index, source |
| rx_valid | input | 1 | Received flit valid |
| rx_head | input | 1 | Received flit is a head |
| rx_ts | input | TS_W | Timestamp of received head |
| lat_sum | output | SUM_W | Accumulated latency |
| pkt_cnt | output | CNT_W | Received packet count |

## Verification
Full-load locality-biased traffic with all channels open separates the launch spacing, the neighbour choice and the exact timestamp value. Half-load uniform traffic from a different node address shows whether the self-skip works and whether far nodes and both channels are reached. Blocking one channel at full load checks that back-pressure holds packets and that they resume correctly. Zero load, an enable drop, and a replayed seed check the idle and determinism rules, and a driven series of received heads, including a zero and a wrapped timestamp, is checked against a scoreboard of expected totals.

// File: rtl/tg_pkg.sv
package tg_pkg;

   typedef enum logic {
      TG_UNIFORM    = 1'b0,
      TG_LOCAL_BIAS = 1'b1
   } tg_mode_e;

   // Galois right-shift feedback masks for the supported generator widths
   function automatic logic [31:0] tg_taps(input int width);
      case (width)
         16:      return 32'h0000_B400;
         24:      return 32'h00E1_0000;
         32:      return 32'h8020_0003;
         default: return 32'h0000_0000;
      endcase
   endfunction

endpackage

// File: rtl/tg_lfsr.sv
module tg_lfsr #(
   parameter int W     = 32,
   parameter int OUT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [W-1:0]     seed,
   output logic [OUT_W-1:0] rnd
);
   localparam logic [W-1:0] TAPS = W'(tg_pkg::tg_taps(W));

   if (TAPS == '0) begin : g_bad_width
      $error("tg_lfsr: width must be 16, 24 or 32");
   end
   if (OUT_W > W) begin : g_bad_out
      $error("tg_lfsr: output slice wider than state");
   end

   logic [W-1:0] s_q;
   logic [W-1:0] s_nxt;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W-1) begin : g_top
         assign s_nxt[i] = TAPS[i] & s_q[0];
      end else begin : g_mid
         assign s_nxt[i] = s_q[i+1] ^ (TAPS[i] & s_q[0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_q <= W'(1);
      end else if (load) begin
         s_q <= (seed == '0) ? W'(1) : seed;
      end else begin
         s_q <= s_nxt;
      end
   end

   assign rnd = s_q[OUT_W-1:0];

endmodule

// File: rtl/tg_dest_sel.sv
module tg_dest_sel #(
   parameter int NODES  = 16,
   parameter int LOAD_W = 8,
   localparam int NODE_W = $clog2(NODES)
) (
   input  tg_pkg::tg_mode_e  mode,
   input  logic [NODE_W-1:0] self_addr,
   input  logic [LOAD_W:0]   local_frac,
   input  logic [LOAD_W-1:0] r_loc,
   input  logic [NODE_W-1:0] r_dst,
   input  logic              r_side,
   output logic [NODE_W-1:0] dest,
   output logic              skip
);
   logic go_local;

   always_comb begin
      go_local = (mode == tg_pkg::TG_LOCAL_BIAS) && ({1'b0, r_loc} < local_frac);
      if (go_local) begin
         dest = r_side ? self_addr + NODE_W'(1) : self_addr - NODE_W'(1);
         skip = 1'b0;
      end else begin
         dest = r_dst;
         skip = (r_dst == self_addr);
      end
   end

endmodule

// File: rtl/tg_pkt_fsm.sv
module tg_pkt_fsm #(
   parameter int NODES     = 16,
   parameter int NUM_VC    = 2,
   parameter int PKT_FLITS = 4,
   parameter int TS_W      = 16,
   parameter int FLIT_W    = 32,
   localparam int NODE_W   = $clog2(NODES),
   localparam int VC_W     = $clog2(NUM_VC),
   localparam int IDX_W    = $clog2(PKT_FLITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NODE_W-1:0] start_dest,
   input  logic [VC_W-1:0]   start_vc,
   input  logic [TS_W-1:0]   start_ts,
   input  logic [NODE_W-1:0] self_addr,
   input  logic [NUM_VC-1:0] vc_ready,
   output logic              busy,
   output logic              flit_valid,
   output logic              flit_head,
   output logic              flit_tail,
   output logic [NODE_W-1:0] flit_dest,
   output logic [VC_W-1:0]   flit_vc,
   output logic [FLIT_W-1:0] flit_data
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(PKT_FLITS - 1);

   logic              busy_q;
   logic [IDX_W-1:0]  idx_q;
   logic [NODE_W-1:0] dest_q;
   logic [NODE_W-1:0] src_q;
   logic [VC_W-1:0]   vc_q;
   logic [TS_W-1:0]   ts_q;
   logic              fire;

   assign fire = busy_q && vc_ready[vc_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         idx_q  <= '0;
         dest_q <= '0;
         src_q  <= '0;
         vc_q   <= '0;
         ts_q   <= '0;
      end else if (start && !busy_q) begin
         busy_q <= 1'b1;
         idx_q  <= '0;
         dest_q <= start_dest;
         src_q  <= self_addr;
         vc_q   <= start_vc;
         ts_q   <= start_ts;
      end else if (fire) begin
         if (idx_q == LAST) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
         end else begin
            idx_q  <= idx_q + IDX_W'(1);
         end
      end
   end

   assign busy       = busy_q;
   assign flit_valid = fire;
   assign flit_head  = fire && (idx_q == '0);
   assign flit_tail  = fire && (idx_q == LAST);
   assign flit_dest  = dest_q;
   assign flit_vc    = vc_q;
   assign flit_data  = FLIT_W'({src_q, idx_q, ts_q});

endmodule

// File: rtl/tg_lat_acc.sv
module tg_lat_acc #(
   parameter int TS_W  = 16,
   parameter int SUM_W = 32,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TS_W-1:0]  now,
   input  logic             rx_valid,
   input  logic             rx_head,
   input  logic [TS_W-1:0]  rx_ts,
   output logic [SUM_W-1:0] lat_sum,
   output logic [CNT_W-1:0] pkt_cnt
);
   if (SUM_W < TS_W) begin : g_bad_sum
      $error("tg_lat_acc: sum narrower than timestamp");
   end

   logic [TS_W-1:0] lat;
   assign lat = now - rx_ts;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_sum <= '0;
         pkt_cnt <= '0;
      end else if (rx_valid && rx_head) begin
         lat_sum <= lat_sum + SUM_W'(lat);
         pkt_cnt <= pkt_cnt + CNT_W'(1);
      end
   end

endmodule

// File: rtl/noc_traffic_gen.sv
module noc_traffic_gen #(
   parameter int NODES     = 16,
   parameter int NUM_VC    = 2,
   parameter int BUF_DEPTH = 8,
   parameter int FLIT_W    = 32,
   parameter int LFSR_W    = 32,
   parameter int LOAD_W    = 8,
   parameter int TS_W      = 16,
   parameter int SUM_W     = 32,
   parameter int CNT_W     = 16,
   localparam int NODE_W    = $clog2(NODES),
   localparam int VC_W      = $clog2(NUM_VC),
   localparam int PKT_FLITS = BUF_DEPTH / 2,
   localparam int IDX_W     = $clog2(PKT_FLITS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              mode,
   input  logic [LFSR_W-1:0] seed,
   input  logic [NODE_W-1:0] self_addr,
   input  logic [LOAD_W:0]   load_rate,
   input  logic [LOAD_W:0]   local_frac,
   input  logic [NUM_VC-1:0] vc_ready,
   output logic              flit_valid,
   output logic              flit_head,
   output logic              flit_tail,
   output logic [NODE_W-1:0] flit_dest,
   output logic [VC_W-1:0]   flit_vc,
   output logic [FLIT_W-1:0] flit_data,
   input  logic              rx_valid,
   input  logic              rx_head,
   input  logic [TS_W-1:0]   rx_ts,
   output logic [SUM_W-1:0]  lat_sum,
   output logic [CNT_W-1:0]  pkt_cnt
);
   // random slice layout
   localparam int P_LOC  = LOAD_W;
   localparam int P_DST  = 2 * LOAD_W;
   localparam int P_SIDE = P_DST + NODE_W;
   localparam int P_VC   = P_SIDE + 1;
   localparam int RND_W  = P_VC + VC_W;

   if (NODES < 4 || (1 << NODE_W) != NODES) begin : g_bad_nodes
      $error("noc_traffic_gen: NODES must be a power of two of at least 4");
   end
   if (NUM_VC < 2 || (1 << VC_W) != NUM_VC) begin : g_bad_vc
      $error("noc_traffic_gen: NUM_VC must be a power of two of at least 2");
   end
   if (BUF_DEPTH < 4 || (1 << IDX_W) != PKT_FLITS) begin : g_bad_depth
      $error("noc_traffic_gen: BUF_DEPTH/2 must be a power of two of at least 2");
   end
   if (RND_W > LFSR_W) begin : g_bad_rnd
      $error("noc_traffic_gen: generator too narrow for the random fields");
   end
   if (FLIT_W < TS_W + IDX_W + NODE_W) begin : g_bad_flit
      $error("noc_traffic_gen: flit too narrow for its fields");
   end

   logic [TS_W-1:0]   now_q;
   logic [RND_W-1:0]  rnd;
   logic [NODE_W-1:0] pick_dest;
   logic              pick_skip;
   logic              busy;
   logic              want;
   logic              start;
   tg_pkg::tg_mode_e  mode_e;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) now_q <= '0;
      else        now_q <= now_q + TS_W'(1);
   end

   assign mode_e = tg_pkg::tg_mode_e'(mode);

   tg_lfsr #(.W(LFSR_W), .OUT_W(RND_W)) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (!en),
      .seed  (seed),
      .rnd   (rnd)
   );

   tg_dest_sel #(.NODES(NODES), .LOAD_W(LOAD_W)) u_dest (
      .mode       (mode_e),
      .self_addr  (self_addr),
      .local_frac (local_frac),
      .r_loc      (rnd[P_LOC +: LOAD_W]),
      .r_dst      (rnd[P_DST +: NODE_W]),
      .r_side     (rnd[P_SIDE]),
      .dest       (pick_dest),
      .skip       (pick_skip)
   );

   assign want  = {1'b0, rnd[LOAD_W-1:0]} < load_rate;
   assign start = en && !busy && want && !pick_skip;

   tg_pkt_fsm #(
      .NODES(NODES), .NUM_VC(NUM_VC), .PKT_FLITS(PKT_FLITS),
      .TS_W(TS_W), .FLIT_W(FLIT_W)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_dest (pick_dest),
      .start_vc   (rnd[P_VC +: VC_W]),
      .start_ts   (now_q),
      .self_addr  (self_addr),
      .vc_ready   (vc_ready),
      .busy       (busy),
      .flit_valid (flit_valid),
      .flit_head  (flit_head),
      .flit_tail  (flit_tail),
      .flit_dest  (flit_dest),
      .flit_vc    (flit_vc),
      .flit_data  (flit_data)
   );

   tg_lat_acc #(.TS_W(TS_W), .SUM_W(SUM_W), .CNT_W(CNT_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .now      (now_q),
      .rx_valid (rx_valid),
      .rx_head  (rx_head),
      .rx_ts    (rx_ts),
      .lat_sum  (lat_sum),
      .pkt_cnt  (pkt_cnt)
   );

endmodule

// File: rtl/noc_traffic_gen_chk.sv
module noc_traffic_gen_chk #(
   parameter int NODES     = 16,
   parameter int NUM_VC    = 2,
   parameter int BUF_DEPTH = 8,
   parameter int LOAD_W    = 8,
   parameter int SUM_W     = 32,
   parameter int CNT_W     = 16,
   localparam int NODE_W    = $clog2(NODES),
   localparam int VC_W      = $clog2(NUM_VC),
   localparam int PKT_FLITS = BUF_DEPTH / 2,
   localparam int IDX_W     = $clog2(PKT_FLITS)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode,
   input logic [NODE_W-1:0] self_addr,
   input logic [LOAD_W:0]   local_frac,
   input logic [NUM_VC-1:0] vc_ready,
   input logic              flit_valid,
   input logic              flit_head,
   input logic              flit_tail,
   input logic [NODE_W-1:0] flit_dest,
   input logic [VC_W-1:0]   flit_vc,
   input logic              rx_valid,
   input logic              rx_head,
   input logic [SUM_W-1:0]  lat_sum,
   input logic [CNT_W-1:0]  pkt_cnt
);
   localparam logic [LOAD_W:0] FULL = (LOAD_W+1)'(1 << LOAD_W);

   logic [IDX_W-1:0] seen_idx;
   logic [VC_W-1:0]  seen_vc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_idx <= '0;
         seen_vc  <= '0;
      end else if (flit_valid) begin
         seen_idx <= flit_tail ? '0 : seen_idx + IDX_W'(1);
         seen_vc  <= flit_vc;
      end
   end

   p_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flit_valid |-> vc_ready[flit_vc]);

   p_head_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_valid && flit_head) |-> (seen_idx == '0));

   p_tail_pos_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_valid && flit_tail) |-> (seen_idx == IDX_W'(PKT_FLITS - 1)));

   p_same_vc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_valid && !flit_head) |-> (flit_vc == seen_vc));

   p_not_self_r5: assert property (@(posedge clk) disable iff (!rst_n)
      flit_valid |-> (flit_dest != self_addr));

   p_neighbour_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (flit_valid && flit_head && mode && local_frac == FULL) |->
      (flit_dest == self_addr + NODE_W'(1) || flit_dest == self_addr - NODE_W'(1)));

   p_count_up_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_head) |=> (pkt_cnt == $past(pkt_cnt) + CNT_W'(1)));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_valid && rx_head) |=> ($stable(pkt_cnt) && $stable(lat_sum)));

endmodule

bind noc_traffic_gen noc_traffic_gen_chk #(
   .NODES(NODES), .NUM_VC(NUM_VC), .BUF_DEPTH(BUF_DEPTH),
   .LOAD_W(LOAD_W), .SUM_W(SUM_W), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mode       (mode),
   .self_addr  (self_addr),
   .local_frac (local_frac),
   .vc_ready   (vc_ready),
   .flit_valid (flit_valid),
   .flit_head  (flit_head),
   .flit_tail  (flit_tail),
   .flit_dest  (flit_dest),
   .flit_vc    (flit_vc),
   .rx_valid   (rx_valid),
   .rx_head    (rx_head),
   .lat_sum    (lat_sum),
   .pkt_cnt    (pkt_cnt)
);

// File: tb/noc_traffic_gen_bench.sv
`timescale 1ns/1ps
module noc_traffic_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        en;
   logic        mode;
   logic [31:0] seed;
   logic [3:0]  self_addr;
   logic [8:0]  load_rate;
   logic [8:0]  local_frac;
   logic [1:0]  vc_ready;
   logic        flit_valid, flit_head, flit_tail;
   logic [3:0]  flit_dest;
   logic [0:0]  flit_vc;
   logic [31:0] flit_data;
   logic        rx_valid, rx_head;
   logic [15:0] rx_ts;
   logic [31:0] lat_sum;
   logic [15:0] pkt_cnt;

   always #2.5 clk = ~clk;

   noc_traffic_gen u_noc_traffic_gen (
      .clk(clk), .rst_n(rst_n), .en(en), .mode(mode), .seed(seed),
      .self_addr(self_addr), .load_rate(load_rate), .local_frac(local_frac),
      .vc_ready(vc_ready), .flit_valid(flit_valid), .flit_head(flit_head),
      .flit_tail(flit_tail), .flit_dest(flit_dest), .flit_vc(flit_vc),
      .flit_data(flit_data), .rx_valid(rx_valid), .rx_head(rx_head),
      .rx_ts(rx_ts), .lat_sum(lat_sum), .pkt_cnt(pkt_cnt)
   );

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   task automatic check(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // reference cycle counter: 0 after reset, +1 each edge
   logic [15:0] bcnt;
   always @(posedge clk or negedge rst_n)
      if (!rst_n) bcnt <= 16'd0;
      else        bcnt <= bcnt + 16'd1;

   // ---------------- flit monitor ----------------
   bit   mon_on = 0, chk_local = 0, chk_gap = 0, chk_ts = 0, rec_on = 0;
   bit   tail_seen = 0, saw_far = 0, saw_vc0 = 0, saw_vc1 = 0;
   int   idx_m = 0, cyc = 0, last_tail = 0, flit_cnt = 0, pkt_heads = 0;
   logic [3:0] cur_dest;
   logic [0:0] cur_vc;
   logic [4:0] rec_q[$];

   always @(negedge clk) begin
      if (rst_n && mon_on) begin
         cyc++;
         if (flit_valid) begin
            flit_cnt++;
            check(vc_ready[flit_vc] == 1'b1, "R3 flit on channel without space", vc_ready, 3);
            check(flit_head == (idx_m == 0), "R2 head flag", flit_head, idx_m == 0);
            check(flit_tail == (idx_m == 3), "R2 tail flag", flit_tail, idx_m == 3);
            check(flit_data[17:16] == idx_m[1:0], "R2 flit index field", flit_data[17:16], idx_m);
            check(flit_data[21:18] == self_addr, "R8 source field", flit_data[21:18], self_addr);
            check(flit_dest != self_addr, "R5 destination equals own node", flit_dest, -1);
            if (flit_head) begin
               pkt_heads++;
               cur_dest = flit_dest;
               cur_vc   = flit_vc;
               if (flit_vc == 1'b0) saw_vc0 = 1; else saw_vc1 = 1;
               if (flit_dest != self_addr + 4'd1 && flit_dest != self_addr - 4'd1) saw_far = 1;
               if (chk_local)
                  check(flit_dest == self_addr + 4'd1 || flit_dest == self_addr - 4'd1,
                        "R6 destination not a neighbour", flit_dest, self_addr + 4'd1);
               if (chk_ts)
                  check(flit_data[15:0] == bcnt - 16'd1, "R8 head timestamp",
                        flit_data[15:0], bcnt - 16'd1);
               if (chk_gap && tail_seen)
                  check(cyc == last_tail + 2, "R4 full-load launch spacing", cyc, last_tail + 2);
               if (rec_on) rec_q.push_back({flit_vc, flit_dest});
            end else begin
               check(flit_dest == cur_dest, "R2 destination changed inside packet", flit_dest, cur_dest);
               check(flit_vc == cur_vc, "R2 channel changed inside packet", flit_vc, cur_vc);
            end
            if (flit_tail) begin
               last_tail = cyc;
               tail_seen = 1;
               idx_m = 0;
            end else begin
               idx_m++;
            end
         end
      end
   end

   // ---------------- latency scoreboard ----------------
   longint sb_sum[$];
   longint sb_cnt[$];
   longint exp_sum = 0, exp_cnt = 0;
   bit sb_arm = 0;

   always @(posedge clk) sb_arm <= (sb_sum.size() > 0);

   always @(negedge clk) begin
      if (sb_arm && sb_sum.size() > 0) begin
         longint es, ec;
         es = sb_sum.pop_front();
         ec = sb_cnt.pop_front();
         check(lat_sum == es, "R10 latency sum", lat_sum, es);
         check(pkt_cnt == ec, "R10 packet count", pkt_cnt, ec);
      end
   end

   task automatic send_rx(input logic v, input logic h, input int k);
      rx_valid = v;
      rx_head  = h;
      rx_ts    = bcnt - 16'(k);
      if (v && h) begin
         exp_sum += k;
         exp_cnt += 1;
      end
      sb_sum.push_back(exp_sum);
      sb_cnt.push_back(exp_cnt);
      @(negedge clk);
   endtask

   // idle, reconfigure, restart
   task automatic go(input logic m, input logic [3:0] sa, input logic [8:0] ld,
                     input logic [8:0] lf, input logic [1:0] rdy,
                     input bit f_local, input bit f_gap, input bit f_ts);
      en = 1'b0;
      vc_ready = 2'b11;
      repeat (12) @(negedge clk);
      mode = m; self_addr = sa; load_rate = ld; local_frac = lf; vc_ready = rdy;
      chk_local = f_local; chk_gap = f_gap; chk_ts = f_ts; tail_seen = 0;
      @(negedge clk);
      en = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [4:0] run1[$];
      int f0;
      rst_n = 1'b0; en = 1'b0; mode = 1'b0; seed = 32'h1ACE_5EED;
      self_addr = 4'd0; load_rate = 9'd0; local_frac = 9'd0; vc_ready = 2'b11;
      rx_valid = 1'b0; rx_head = 1'b0; rx_ts = 16'd0;
      repeat (3) @(negedge clk);
      check(flit_valid == 1'b0, "R1 flit_valid in reset", flit_valid, 0);
      check(lat_sum == 32'd0, "R1 lat_sum in reset", lat_sum, 0);
      check(pkt_cnt == 16'd0, "R1 pkt_cnt in reset", pkt_cnt, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(flit_valid == 1'b0, "R1 flit_valid after reset", flit_valid, 0);
      mon_on = 1;

      // A: full load, all-neighbour traffic, open channels
      go(1'b1, 4'd0, 9'd256, 9'd256, 2'b11, 1, 1, 1);
      repeat (200) @(negedge clk);
      check(pkt_heads >= 35, "R4 packets launched at full load", pkt_heads, 35);

      // B: half load, uniform, node 5
      go(1'b0, 4'd5, 9'd128, 9'd0, 2'b11, 0, 0, 1);
      f0 = pkt_heads;
      repeat (600) @(negedge clk);
      check(pkt_heads > f0 + 10, "R4 packets at half load", pkt_heads, f0 + 10);
      check(saw_far, "R5 non-neighbour destinations reached", saw_far, 1);
      check(saw_vc0 && saw_vc1, "R7 both channels used", {saw_vc1, saw_vc0}, 3);

      // C: channel 1 has no space
      go(1'b0, 4'd5, 9'd256, 9'd0, 2'b01, 0, 0, 0);
      repeat (300) @(negedge clk);
      f0 = flit_cnt;
      vc_ready = 2'b11;
      repeat (100) @(negedge clk);
      check(flit_cnt > f0, "R3 traffic resumes when space returns", flit_cnt, f0 + 1);

      // D: zero load
      go(1'b0, 4'd5, 9'd0, 9'd0, 2'b11, 0, 0, 1);
      f0 = flit_cnt;
      repeat (200) @(negedge clk);
      check(flit_cnt == f0, "R4 no flits at zero load", flit_cnt, f0);

      // E: seed replay and enable low
      go(1'b0, 4'd3, 9'd256, 9'd0, 2'b11, 0, 0, 1);
      rec_q.delete();
      rec_on = 1;
      for (int i = 0; i < 400 && rec_q.size() < 6; i++) @(negedge clk);
      rec_on = 0;
      check(rec_q.size() >= 6, "R9 first run produced packets", rec_q.size(), 6);
      run1 = rec_q;
      en = 1'b0;
      repeat (10) @(negedge clk);
      f0 = flit_cnt;
      repeat (100) @(negedge clk);
      check(flit_cnt == f0, "R9 no flits while disabled", flit_cnt, f0);
      rec_q.delete();
      rec_on = 1;
      en = 1'b1;
      for (int i = 0; i < 400 && rec_q.size() < 6; i++) @(negedge clk);
      rec_on = 0;
      for (int i = 0; i < 6; i++) begin
         if (i < run1.size() && i < rec_q.size())
            check(rec_q[i] == run1[i], "R9 replayed sequence", rec_q[i], run1[i]);
         else
            check(1'b0, "R9 replayed sequence length", rec_q.size(), 6);
      end

      // F: latency accumulator
      go(1'b0, 4'd3, 9'd0, 9'd0, 2'b11, 0, 0, 0);
      send_rx(1'b1, 1'b1, 7);
      send_rx(1'b1, 1'b1, 1);
      send_rx(1'b1, 1'b0, 5);
      send_rx(1'b0, 1'b1, 9);
      send_rx(1'b1, 1'b1, 0);
      send_rx(1'b1, 1'b1, 300);
      send_rx(1'b1, 1'b1, 40000);
      rx_valid = 1'b0;
      rx_head  = 1'b0;
      repeat (3) @(negedge clk);
      check(sb_sum.size() == 0, "R10 scoreboard drained", sb_sum.size(), 0);
      check(pkt_cnt == 16'd5, "R10 final packet count", pkt_cnt, 5);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule